// File: doc/BRIEF.md
# Coin Vending Controller with Change

This block is the sequencing core of a small vending machine that offers three items. A single select key both chooses the item and later confirms the purchase. Three coin keys add credit in steps of one tenth of a currency unit. All inputs are clean single-cycle pulses. Debouncing, display scanning, segment decoding and clock division are handled elsewhere.

From idle, the first select press picks item A. Further presses, made before any coin, step the choice to B and then to C. The first coin moves the block into accumulating credit. Once credit covers the price, a select press completes the sale. The block then emits a one-clock dispense strobe for the chosen item, keeps credit minus price as the change, and returns to idle.

The credit, or the change after a sale, is presented as three BCD digits: two whole-unit digits and one tenths digit. The change is also given as separate unit and tenth fields.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_n` is low, the block is idle with zero credit. All item indicators, dispense strobes, display digits and change fields are zero, and they stay so until a select press arrives after release.
- R2: From idle, a select pulse lights indicator bit 0 (item A). While no coin has been accepted, each further select pulse moves to bit 1 (B) and then bit 2 (C). A select pulse while C is chosen and no coin has been accepted changes nothing.
- R3: The select pulse that starts a selection clears the credit, so the display reads 0,0,0.
- R4: Outside idle, a pulse on `coin_unit` adds 10 tenths, on `coin_half` adds 5, and on `coin_tenth` adds 1. The first coin ends item stepping: after it, a select pulse no longer changes the lit indicator.
- R5: Coin pulses received while idle leave the credit, the display and the change fields unchanged.
- R6: While accumulating, a select pulse with credit at least the price (A=10, B=15, C=16 tenths) sets the credit to credit minus price, returns to idle and turns all indicators off.
- R7: While accumulating, a select pulse with credit below the price changes nothing: the indicator stays lit and the credit is kept.
- R8: `dispense` is high for exactly one cycle, starting with the first cycle after the clock edge that sampled the completing select pulse. Bit 0 is A, bit 1 is B and bit 2 is C.
- R9: The display gives `disp_unit_hi` = tens of units, `disp_unit_lo` = units and `disp_tenth` = tenths of the credit. A credit above 99 tenths is shown as 0,9,9.
- R10: The credit register saturates at 127 tenths (2^CREDIT_W-1) instead of wrapping. Starting from 127, a sale of A leaves 117 tenths of change.
- R11: In idle, `chg_units` and `chg_tenths` give the held credit (the change) as whole units and tenths. While selecting or accumulating they read zero.
- R12: When several pulses arrive in the same cycle, select takes priority over every coin, and only the largest coin is taken among coins. The other pulses of that cycle are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_key | input | 1 | Select / confirm pulse |
| coin_unit | input | 1 | Coin pulse worth 10 tenths |
| coin_half | input | 1 | Coin pulse worth 5 tenths |
| coin_tenth | input | 1 | Coin pulse worth 1 tenth |
| item_led | output | 3 | One-hot indicator of the chosen item (bit 0 A, 1 B, 2 C) |
| dispense | output | 3 | One-cycle dispense strobe per item |
| disp_unit_hi | output | 4 | Tens-of-units BCD digit of the shown value |
| disp_unit_lo | output | 4 | Units BCD digit of the shown value |
| disp_tenth | output | 4 | Tenths BCD digit of the shown value |
| chg_units | output | 4 | Whole units of change (UNITS_W bits) |
| chg_tenths | output | 4 | Tenths of change |

## Verification
The bench targets exact-price sales for B and C. An off-by-one credit comparison would either refuse these sales or accept a press that is one tenth short. It also presses select together with coins: a design with the wrong priority would credit a coin or step the item when it should not. A stack of whole-unit coins drives the credit past both the display cap and the register limit. A wrapping register would then refuse the sale or report a small change, and a missing display cap would show a second units digit. Coins pressed in idle and a select press after the first coin check that the state machine stays where it should.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PICK  = 2'd1,
    ST_ACCUM = 2'd2
  } vend_state_e;

  typedef enum logic [1:0] {
    ITEM_A = 2'd0,
    ITEM_B = 2'd1,
    ITEM_C = 2'd2
  } item_e;

  typedef enum logic [1:0] {
    CR_HOLD  = 2'd0,
    CR_CLEAR = 2'd1,
    CR_ADD   = 2'd2,
    CR_SUB   = 2'd3
  } credit_op_e;

  localparam int N_ITEMS = 3;

endpackage

// File: rtl/vend_rst_sync.sv
module vend_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/vend_credit.sv
module vend_credit
  import vend_pkg::*;
#(
  parameter int CREDIT_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  credit_op_e          op,
  input  logic [CREDIT_W-1:0] amount,
  output logic [CREDIT_W-1:0] credit
);

  localparam logic [CREDIT_W-1:0] CREDIT_MAX = {CREDIT_W{1'b1}};

  logic [CREDIT_W-1:0] credit_q;
  logic [CREDIT_W-1:0] credit_d;
  logic [CREDIT_W:0]   sum;
  logic                upd_en;

  assign sum    = {1'b0, credit_q} + {1'b0, amount};
  assign upd_en = (op != CR_HOLD);

  always_comb begin
    credit_d = credit_q;
    unique case (op)
      CR_CLEAR: credit_d = '0;
      CR_ADD:   credit_d = sum[CREDIT_W] ? CREDIT_MAX : sum[CREDIT_W-1:0];
      CR_SUB:   credit_d = credit_q - amount;
      default:  credit_d = credit_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= '0;
    end else if (upd_en) begin
      credit_q <= credit_d;
    end
  end

  assign credit = credit_q;

endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
  import vend_pkg::*;
#(
  parameter int CREDIT_W   = 7,
  parameter int PRICE_A    = 10,
  parameter int PRICE_B    = 15,
  parameter int PRICE_C    = 16,
  parameter int COIN_BIG   = 10,
  parameter int COIN_MID   = 5,
  parameter int COIN_SMALL = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_key,
  input  logic                coin_big,
  input  logic                coin_mid,
  input  logic                coin_small,
  input  logic [CREDIT_W-1:0] credit,
  output vend_state_e         state,
  output item_e               item,
  output logic [N_ITEMS-1:0]  dispense,
  output credit_op_e          op,
  output logic [CREDIT_W-1:0] amount
);

  localparam logic [CREDIT_W-1:0] P_A = CREDIT_W'(PRICE_A);
  localparam logic [CREDIT_W-1:0] P_B = CREDIT_W'(PRICE_B);
  localparam logic [CREDIT_W-1:0] P_C = CREDIT_W'(PRICE_C);
  localparam logic [CREDIT_W-1:0] C_BIG   = CREDIT_W'(COIN_BIG);
  localparam logic [CREDIT_W-1:0] C_MID   = CREDIT_W'(COIN_MID);
  localparam logic [CREDIT_W-1:0] C_SMALL = CREDIT_W'(COIN_SMALL);

  vend_state_e          state_q, state_d;
  item_e                item_q, item_d;
  logic [N_ITEMS-1:0]   disp_q, disp_d;
  logic [CREDIT_W-1:0]  coin_amt;
  logic                 coin_any;
  logic [CREDIT_W-1:0]  price;

  // coin priority: larger value wins (R12)
  always_comb begin
    coin_any = coin_big | coin_mid | coin_small;
    if (coin_big)      coin_amt = C_BIG;
    else if (coin_mid) coin_amt = C_MID;
    else if (coin_small) coin_amt = C_SMALL;
    else               coin_amt = '0;
  end

  always_comb begin
    unique case (item_q)
      ITEM_B:  price = P_B;
      ITEM_C:  price = P_C;
      default: price = P_A;
    endcase
  end

  // next-state process; select is tested before coins (R12)
  always_comb begin
    state_d = state_q;
    item_d  = item_q;
    disp_d  = '0;
    op      = CR_HOLD;
    amount  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (sel_key) begin
          state_d = ST_PICK;
          item_d  = ITEM_A;
          op      = CR_CLEAR;
        end
      end
      ST_PICK: begin
        if (sel_key) begin
          item_d = (item_q == ITEM_A) ? ITEM_B : ITEM_C;
        end else if (coin_any) begin
          state_d = ST_ACCUM;
          op      = CR_ADD;
          amount  = coin_amt;
        end
      end
      ST_ACCUM: begin
        if (sel_key) begin
          if (credit >= price) begin
            state_d = ST_IDLE;
            op      = CR_SUB;
            amount  = price;
            disp_d[item_q] = 1'b1;
          end
        end else if (coin_any) begin
          op     = CR_ADD;
          amount = coin_amt;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      item_q  <= ITEM_A;
      disp_q  <= '0;
    end else begin
      state_q <= state_d;
      item_q  <= item_d;
      disp_q  <= disp_d;
    end
  end

  assign state    = state_q;
  assign item     = item_q;
  assign dispense = disp_q;

endmodule

// File: rtl/vend_digits.sv
module vend_digits #(
  parameter int VAL_W = 7,
  parameter int CAP   = 99
) (
  input  logic [VAL_W-1:0] value,
  output logic [3:0]       d_unit_hi,
  output logic [3:0]       d_unit_lo,
  output logic [3:0]       d_tenth
);

  localparam logic [VAL_W-1:0] CAP_V = VAL_W'(CAP);
  localparam logic [VAL_W-1:0] TEN   = VAL_W'(10);

  logic [VAL_W-1:0] capped;
  logic [VAL_W-1:0] units;

  always_comb begin
    capped    = (value > CAP_V) ? CAP_V : value;
    units     = capped / TEN;
    d_unit_hi = 4'(units / TEN);
    d_unit_lo = 4'(units % TEN);
    d_tenth   = 4'(capped % TEN);
  end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int CREDIT_W   = 7,
  parameter int PRICE_A    = 10,
  parameter int PRICE_B    = 15,
  parameter int PRICE_C    = 16,
  parameter int COIN_BIG   = 10,
  parameter int COIN_MID   = 5,
  parameter int COIN_SMALL = 1,
  parameter int DISP_CAP   = 99,
  localparam int UNITS_W   = $clog2(((1 << CREDIT_W) - 1) / 10 + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_key,
  input  logic               coin_unit,
  input  logic               coin_half,
  input  logic               coin_tenth,
  output logic [2:0]         item_led,
  output logic [2:0]         dispense,
  output logic [3:0]         disp_unit_hi,
  output logic [3:0]         disp_unit_lo,
  output logic [3:0]         disp_tenth,
  output logic [UNITS_W-1:0] chg_units,
  output logic [3:0]         chg_tenths
);

  localparam logic [CREDIT_W-1:0] TEN = CREDIT_W'(10);

  logic                rst_sync_n;
  vend_state_e         state;
  item_e               item;
  credit_op_e          op;
  logic [CREDIT_W-1:0] amount;
  logic [CREDIT_W-1:0] credit;
  logic [CREDIT_W-1:0] chg_val;

  vend_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  vend_fsm #(
    .CREDIT_W   (CREDIT_W),
    .PRICE_A    (PRICE_A),
    .PRICE_B    (PRICE_B),
    .PRICE_C    (PRICE_C),
    .COIN_BIG   (COIN_BIG),
    .COIN_MID   (COIN_MID),
    .COIN_SMALL (COIN_SMALL)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sel_key    (sel_key),
    .coin_big   (coin_unit),
    .coin_mid   (coin_half),
    .coin_small (coin_tenth),
    .credit     (credit),
    .state      (state),
    .item       (item),
    .dispense   (dispense),
    .op         (op),
    .amount     (amount)
  );

  vend_credit #(.CREDIT_W(CREDIT_W)) u_credit (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .op     (op),
    .amount (amount),
    .credit (credit)
  );

  vend_digits #(.VAL_W(CREDIT_W), .CAP(DISP_CAP)) u_digits (
    .value     (credit),
    .d_unit_hi (disp_unit_hi),
    .d_unit_lo (disp_unit_lo),
    .d_tenth   (disp_tenth)
  );

  // indicators lit only while an item is chosen
  generate
    for (genvar gi = 0; gi < N_ITEMS; gi++) begin : g_led
      assign item_led[gi] = (state != ST_IDLE) && (item == item_e'(gi));
    end
  endgenerate

  // change fields: the held credit while idle
  always_comb begin
    chg_val    = (state == ST_IDLE) ? credit : '0;
    chg_units  = UNITS_W'(chg_val / TEN);
    chg_tenths = 4'(chg_val % TEN);
  end

endmodule

// File: rtl/vend_ctrl_checker.sv
module vend_ctrl_checker
  import vend_pkg::*;
#(
  parameter int CREDIT_W = 7,
  parameter int PRICE_A  = 10,
  parameter int PRICE_B  = 15,
  parameter int PRICE_C  = 16,
  parameter int UNITS_W  = 4
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                sel_key,
  input logic [2:0]          item_led,
  input logic [2:0]          dispense,
  input logic [3:0]          disp_unit_hi,
  input logic [3:0]          disp_unit_lo,
  input logic [3:0]          disp_tenth,
  input logic [UNITS_W-1:0]  chg_units,
  input logic [3:0]          chg_tenths,
  input vend_state_e         state,
  input item_e               item,
  input logic [CREDIT_W-1:0] credit
);

  logic [CREDIT_W-1:0] cur_price;
  logic [CREDIT_W-1:0] sold_price;

  always_comb begin
    unique case (item)
      ITEM_B:  cur_price = CREDIT_W'(PRICE_B);
      ITEM_C:  cur_price = CREDIT_W'(PRICE_C);
      default: cur_price = CREDIT_W'(PRICE_A);
    endcase
    if (dispense[2])      sold_price = CREDIT_W'(PRICE_C);
    else if (dispense[1]) sold_price = CREDIT_W'(PRICE_B);
    else                  sold_price = CREDIT_W'(PRICE_A);
  end

  p_led_onehot_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(item_led));

  p_sel_clear_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_IDLE && sel_key) |=> (credit == '0));

  p_idle_coin_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_IDLE && !sel_key) |=> $stable(credit));

  p_sale_change_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dispense != 3'b000) |-> (credit == $past(credit) - sold_price));

  p_leds_off_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dispense != 3'b000) |-> (item_led == 3'b000));

  p_short_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state == ST_ACCUM && sel_key && credit < cur_price)
      |=> (state == ST_ACCUM && item_led == $past(item_led)));

  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dispense != 3'b000) |=> (dispense == 3'b000));

  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(dispense));

  p_disp_cap_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    disp_unit_hi == 4'd0 && disp_unit_lo <= 4'd9 && disp_tenth <= 4'd9);

  p_chg_zero_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state != ST_IDLE) |-> (chg_units == '0 && chg_tenths == 4'd0));

endmodule

bind vend_ctrl vend_ctrl_checker #(
  .CREDIT_W (CREDIT_W),
  .PRICE_A  (PRICE_A),
  .PRICE_B  (PRICE_B),
  .PRICE_C  (PRICE_C),
  .UNITS_W  (UNITS_W)
) u_checker (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .sel_key      (sel_key),
  .item_led     (item_led),
  .dispense     (dispense),
  .disp_unit_hi (disp_unit_hi),
  .disp_unit_lo (disp_unit_lo),
  .disp_tenth   (disp_tenth),
  .chg_units    (chg_units),
  .chg_tenths   (chg_tenths),
  .state        (state),
  .item         (item),
  .credit       (credit)
);

// File: tb/vend_ctrl_bench.sv
module vend_ctrl_bench;

  logic       clk;
  logic       rst_n;
  logic       sel_key, coin_unit, coin_half, coin_tenth;
  logic [2:0] item_led, dispense;
  logic [3:0] disp_unit_hi, disp_unit_lo, disp_tenth;
  logic [3:0] chg_units, chg_tenths;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  vend_ctrl u_vend_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_key      (sel_key),
    .coin_unit    (coin_unit),
    .coin_half    (coin_half),
    .coin_tenth   (coin_tenth),
    .item_led     (item_led),
    .dispense     (dispense),
    .disp_unit_hi (disp_unit_hi),
    .disp_unit_lo (disp_unit_lo),
    .disp_tenth   (disp_tenth),
    .chg_units    (chg_units),
    .chg_tenths   (chg_tenths)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: {sel,unit,half,tenth} {led} {hi,lo,tenth BCD} {dispense} {chg_u} {chg_t}
  localparam int NV = 24;
  localparam logic [29:0] VEC [NV] = '{
    {4'b0001, 3'b000, 12'h000, 3'b000, 4'h0, 4'h0}, // R5 coin in idle
    {4'b1000, 3'b001, 12'h000, 3'b000, 4'h0, 4'h0}, // R2 pick A
    {4'b1000, 3'b010, 12'h000, 3'b000, 4'h0, 4'h0}, // R2 step to B
    {4'b1000, 3'b100, 12'h000, 3'b000, 4'h0, 4'h0}, // R2 step to C
    {4'b1000, 3'b100, 12'h000, 3'b000, 4'h0, 4'h0}, // R2 C holds
    {4'b0100, 3'b100, 12'h010, 3'b000, 4'h0, 4'h0}, // R4 +10
    {4'b1000, 3'b100, 12'h010, 3'b000, 4'h0, 4'h0}, // R7 short
    {4'b0010, 3'b100, 12'h015, 3'b000, 4'h0, 4'h0}, // R4 +5
    {4'b1000, 3'b100, 12'h015, 3'b000, 4'h0, 4'h0}, // R7 one tenth short
    {4'b0001, 3'b100, 12'h016, 3'b000, 4'h0, 4'h0}, // R4 +1
    {4'b1000, 3'b000, 12'h000, 3'b100, 4'h0, 4'h0}, // R6 exact sale C
    {4'b0000, 3'b000, 12'h000, 3'b000, 4'h0, 4'h0}, // R8 strobe ends
    {4'b1000, 3'b001, 12'h000, 3'b000, 4'h0, 4'h0}, // R2 pick A
    {4'b1100, 3'b010, 12'h000, 3'b000, 4'h0, 4'h0}, // R12 select beats coin
    {4'b0111, 3'b010, 12'h010, 3'b000, 4'h0, 4'h0}, // R12 largest coin
    {4'b0011, 3'b010, 12'h015, 3'b000, 4'h0, 4'h0}, // R12 half beats tenth
    {4'b1001, 3'b000, 12'h000, 3'b010, 4'h0, 4'h0}, // R12 sale B, coin dropped
    {4'b1000, 3'b001, 12'h000, 3'b000, 4'h0, 4'h0}, // R3 pick A, zero credit
    {4'b0100, 3'b001, 12'h010, 3'b000, 4'h0, 4'h0}, // R4
    {4'b0100, 3'b001, 12'h020, 3'b000, 4'h0, 4'h0}, // R4
    {4'b0001, 3'b001, 12'h021, 3'b000, 4'h0, 4'h0}, // R4
    {4'b1000, 3'b000, 12'h011, 3'b001, 4'h1, 4'h1}, // R6 sale A, change 1.1
    {4'b0001, 3'b000, 12'h011, 3'b000, 4'h1, 4'h1}, // R5 idle coin ignored
    {4'b1000, 3'b001, 12'h000, 3'b000, 4'h0, 4'h0}  // R3 R11 new pick clears
  };
  localparam int VREQ [NV] = '{5,2,2,2,2,4,7,4,7,4,6,8,2,12,12,12,12,3,4,4,4,6,5,3};

  function automatic logic [25:0] observed();
    return {item_led, disp_unit_hi, disp_unit_lo, disp_tenth, dispense, chg_units, chg_tenths};
  endfunction

  task automatic check(input string req, input logic [25:0] exp_v);
    logic [25:0] act;
    act = observed();
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  task automatic pulse(input logic s, input logic u, input logic h, input logic t);
    sel_key = s; coin_unit = u; coin_half = h; coin_tenth = t;
    @(negedge clk);
    sel_key = 0; coin_unit = 0; coin_half = 0; coin_tenth = 0;
  endtask

  initial begin
    rst_n = 0; sel_key = 0; coin_unit = 0; coin_half = 0; coin_tenth = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", 26'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 after release", 26'h0);

    for (int i = 0; i < NV; i++) begin
      {sel_key, coin_unit, coin_half, coin_tenth} = VEC[i][29:26];
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VREQ[i], i), VEC[i][25:0]);
    end
    sel_key = 0; coin_unit = 0; coin_half = 0; coin_tenth = 0;

    // R9: display cap; item A chosen, credit 0
    for (int k = 0; k < 9; k++) pulse(0, 1, 0, 0);
    check("R9 credit 90", {3'b001, 12'h090, 3'b000, 4'h0, 4'h0});
    pulse(0, 1, 0, 0);
    check("R9 credit 100 capped", {3'b001, 12'h099, 3'b000, 4'h0, 4'h0});
    // R10: saturate at 127, sale A leaves 117
    for (int k = 0; k < 3; k++) pulse(0, 1, 0, 0);
    check("R10 saturated display", {3'b001, 12'h099, 3'b000, 4'h0, 4'h0});
    pulse(1, 0, 0, 0);
    check("R10 R11 change 11.7", {3'b000, 12'h099, 3'b001, 4'hB, 4'h7});
    @(negedge clk);
    check("R8 R11 change held", {3'b000, 12'h099, 3'b000, 4'hB, 4'h7});

    // R1: asynchronous reset in mid-purchase
    pulse(1, 0, 0, 0);
    pulse(0, 0, 1, 0);
    check("R4 credit 0.5", {3'b001, 12'h005, 3'b000, 4'h0, 4'h0});
    #2 rst_n = 0;
    #1 check("R1 async reset", 26'h0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    pulse(0, 1, 0, 0);
    check("R1 R5 idle after reset", 26'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule